// File: doc/BRIEF.md
# PLL Divider Configuration Validator

This block vets a requested setting for a fractional clock multiplier before software or a sequencer commits it to the PLL. A setting consists of a pre-divider P, an integer multiplier J and a four-decimal-digit fraction D, which together give the multiplier K = J + D/10000. The reference frequency is supplied as an integer number of kHz.

On an accepted start strobe, the block captures the setting. It checks the encoding, the divided reference and J at once. It then forms the scaled multiplier J·10000 + D. A serial shift-add multiplier produces the product of that value and the reference, which is compared against the oscillator window scaled by P. No divider is used anywhere.

When the check finishes, a one-cycle done pulse appears together with a valid flag and one error bit per violated rule. Those results stay put until the next accepted start. The permitted ranges for the divided reference and for J depend on whether D is zero (integer mode) or nonzero (fractional mode).

Top module: `pll_cfg_checker`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, busy, done and valid are low and err is all zero.
- R2: A start that is seen while busy is low is accepted and raises busy. Counting the accepting rising edge as edge 1, done is high after edge KS_W+2 and busy falls at that same edge. KS_W is the bit width needed for the largest J·10000+D; it is 20 with the default parameters, which gives 22 edges.
- R3: A start that arrives while busy is high is ignored. The check in flight finishes at its normal time and reports results for the settings that were captured when it was accepted.
- R4: done is high for exactly one cycle. err and valid stay unchanged from the done pulse until the next accepted start, even if the inputs change.
- R5: P = 0 sets err bit 0, and D above 9999 sets err bit 1. When either of these bits is set, err bits 7..2 read zero.
- R6: In integer mode (D = 0), err bit 2 flags MCLK/P below 2000 kHz and err bit 3 flags MCLK/P above 20000 kHz. Both bounds are inclusive and pass.
- R7: In fractional mode (D ≠ 0), err bit 2 flags MCLK/P below 10000 kHz and err bit 3 flags MCLK/P above 20000 kHz. Both bounds are inclusive and pass.
- R8: In integer mode, err bit 4 flags J below 4 and err bit 5 flags J above 55.
- R9: In fractional mode, err bit 4 flags J below 4 and err bit 5 flags J above 11.
- R10: err bit 6 flags MCLK·(J·10000+D) below P·8·10^8, and err bit 7 flags it above P·1.1·10^9. Both bounds are inclusive and pass.
- R11: valid is high exactly when all err bits are zero.
- R12: A 12000 kHz reference with P=1, J=7, D=5264 is reported valid, and so is P=1, J=8, D=1920.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a check of the presented setting |
| mclk_khz | input | REF_W | Reference frequency in kHz |
| pdiv | input | P_W | Pre-divider P |
| jmul | input | J_W | Integer multiplier J |
| dfrac | input | D_W | Fraction D in units of 1/10000 |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle result strobe |
| valid | output | 1 | Setting obeys every rule |
| err | output | 8 | Rule violation bits; see R5 to R10 |

## Verification
The bench uses the default widths: a 17-bit reference, a 4-bit P, a 6-bit J and a 14-bit D. These widths allow references up to 131 MHz, pre-dividers up to 15, J beyond 55 and D beyond 9999, so every rule can be violated from the ports. A P of 2 is used to show that the divided-reference and product windows scale with the pre-divider. Inclusive bounds are hit exactly, at 2000 kHz with J=55 (product exactly 1.1·10^9) and at a product equal to 2·8·10^8, along with one kHz below the latter. The default width of the scaled multiplier fixes the latency the bench expects at 22 edges.

// File: rtl/pll_chk_pkg.sv
// Package: shared error record for the PLL configuration validator.
// Bit order is part of the port contract (bit 0 = p_zero ... bit 7 = vco_high).
package pll_chk_pkg;
    typedef struct packed {
        logic vco_high;   // bit 7
        logic vco_low;    // bit 6
        logic j_high;     // bit 5
        logic j_low;      // bit 4
        logic fdiv_high;  // bit 3
        logic fdiv_low;   // bit 2
        logic d_range;    // bit 1
        logic p_zero;     // bit 0
    } pll_err_t;
endpackage

// File: rtl/pll_serial_mul.sv
// Module: unsigned shift-add multiplier, one multiplier bit per cycle.
// Assumes: load is only honoured while idle; result is valid when fin pulses
// and stays until the next load.
module pll_serial_mul #(
    parameter int A_W = 17,
    parameter int B_W = 20,
    localparam int R_W = A_W + B_W,
    localparam int C_W = $clog2(B_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic           fin,
    output logic [R_W-1:0] prod
);
    logic           running;
    logic [C_W-1:0] cnt;
    logic [R_W-1:0] acc;
    logic [R_W-1:0] mcand;
    logic [B_W-1:0] mplier;

    // Load operands, then add shifted multiplicand for each set multiplier bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            fin     <= 1'b0;
            cnt     <= '0;
            acc     <= '0;
            mcand   <= '0;
            mplier  <= '0;
        end else begin
            fin <= 1'b0;
            if (load && !running) begin
                running <= 1'b1;
                cnt     <= '0;
                acc     <= '0;
                mcand   <= R_W'(a);
                mplier  <= b;
            end else if (running) begin
                if (mplier[0]) acc <= acc + mcand;
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                cnt    <= cnt + 1'b1;
                if (cnt == C_W'(B_W - 1)) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end
            end
        end
    end

    assign prod = acc;
endmodule

// File: rtl/pll_static_rules.sv
// Module: single-cycle rules that need no long product: encoding, divided
// reference window and J window, each picking integer or fractional limits.
// Assumes: limits in kHz; divided reference compared as MCLK vs P*limit.
module pll_static_rules
    import pll_chk_pkg::*;
#(
    parameter int REF_W         = 17,
    parameter int P_W           = 4,
    parameter int J_W           = 6,
    parameter int D_W           = 14,
    parameter int FRAC_SCALE    = 10000,
    parameter int FDIV_MIN_INT  = 2000,
    parameter int FDIV_MIN_FRAC = 10000,
    parameter int FDIV_MAX      = 20000,
    parameter int J_MIN         = 4,
    parameter int J_MAX_INT     = 55,
    parameter int J_MAX_FRAC    = 11
) (
    input  logic [REF_W-1:0] mclk_khz,
    input  logic [P_W-1:0]   pdiv,
    input  logic [J_W-1:0]   jmul,
    input  logic [D_W-1:0]   dfrac,
    output pll_err_t         rules
);
    logic        frac_mode;
    logic [63:0] fd_lo;
    logic [63:0] fd_hi;
    logic [63:0] j_hi;

    // Select mode-dependent limits and evaluate each rule.
    always_comb begin
        frac_mode = (dfrac != '0);
        fd_lo = 64'(pdiv) * 64'(frac_mode ? FDIV_MIN_FRAC : FDIV_MIN_INT);
        fd_hi = 64'(pdiv) * 64'(FDIV_MAX);
        j_hi  = 64'(frac_mode ? J_MAX_FRAC : J_MAX_INT);
        rules           = '0;
        rules.p_zero    = (pdiv == '0);
        rules.d_range   = (64'(dfrac) >= 64'(FRAC_SCALE));
        rules.fdiv_low  = (64'(mclk_khz) < fd_lo);
        rules.fdiv_high = (64'(mclk_khz) > fd_hi);
        rules.j_low     = (64'(jmul) < 64'(J_MIN));
        rules.j_high    = (64'(jmul) > j_hi);
    end
endmodule

// File: rtl/pll_cfg_checker.sv
// Module: top of the PLL configuration validator.
// Captures a setting on an accepted start, runs the serial product, then
// posts a one-cycle done with valid and err held until the next start.
// Assumes: start while busy is dropped; encoding faults mask range bits.
module pll_cfg_checker
    import pll_chk_pkg::*;
#(
    parameter int REF_W         = 17,
    parameter int P_W           = 4,
    parameter int J_W           = 6,
    parameter int D_W           = 14,
    parameter int FRAC_SCALE    = 10000,
    parameter int FDIV_MIN_INT  = 2000,
    parameter int FDIV_MIN_FRAC = 10000,
    parameter int FDIV_MAX      = 20000,
    parameter int J_MIN         = 4,
    parameter int J_MAX_INT     = 55,
    parameter int J_MAX_FRAC    = 11,
    parameter int VCO_MIN_KHZ   = 80000,
    parameter int VCO_MAX_KHZ   = 110000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REF_W-1:0] mclk_khz,
    input  logic [P_W-1:0]   pdiv,
    input  logic [J_W-1:0]   jmul,
    input  logic [D_W-1:0]   dfrac,
    output logic             busy,
    output logic             done,
    output logic             valid,
    output logic [7:0]       err
);
    localparam longint KS_MAX = (longint'(2) ** J_W - 1) * longint'(FRAC_SCALE)
                              + (longint'(2) ** D_W - 1);
    localparam int KS_W = $clog2(KS_MAX + 1);
    localparam int PR_W = REF_W + KS_W;

    logic            busy_q;
    logic            done_q;
    logic            valid_q;
    pll_err_t        err_q;
    pll_err_t        st_now;
    pll_err_t        st_q;
    pll_err_t        fin_err;
    logic [P_W-1:0]  p_q;
    logic [KS_W-1:0] ks_in;
    logic            accept;
    logic            mul_fin;
    logic [PR_W-1:0] mul_prod;
    logic [63:0]     vco_lo;
    logic [63:0]     vco_hi;

    assign accept = start && !busy_q;
    assign ks_in  = KS_W'(64'(jmul) * 64'(FRAC_SCALE) + 64'(dfrac));

    pll_static_rules #(
        .REF_W(REF_W), .P_W(P_W), .J_W(J_W), .D_W(D_W),
        .FRAC_SCALE(FRAC_SCALE), .FDIV_MIN_INT(FDIV_MIN_INT),
        .FDIV_MIN_FRAC(FDIV_MIN_FRAC), .FDIV_MAX(FDIV_MAX),
        .J_MIN(J_MIN), .J_MAX_INT(J_MAX_INT), .J_MAX_FRAC(J_MAX_FRAC)
    ) u_rules (
        .mclk_khz(mclk_khz), .pdiv(pdiv), .jmul(jmul), .dfrac(dfrac),
        .rules(st_now)
    );

    pll_serial_mul #(.A_W(REF_W), .B_W(KS_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .a(mclk_khz), .b(ks_in), .fin(mul_fin), .prod(mul_prod)
    );

    // Merge the product window with captured rules; encoding faults win.
    always_comb begin
        vco_lo  = 64'(p_q) * 64'(VCO_MIN_KHZ) * 64'(FRAC_SCALE);
        vco_hi  = 64'(p_q) * 64'(VCO_MAX_KHZ) * 64'(FRAC_SCALE);
        fin_err = st_q;
        fin_err.vco_low  = (64'(mul_prod) < vco_lo);
        fin_err.vco_high = (64'(mul_prod) > vco_hi);
        if (st_q.p_zero || st_q.d_range) begin
            fin_err         = '0;
            fin_err.p_zero  = st_q.p_zero;
            fin_err.d_range = st_q.d_range;
        end
    end

    // Sequence: capture on accept, publish results when the product lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            err_q   <= '0;
            st_q    <= '0;
            p_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                st_q   <= st_now;
                p_q    <= pdiv;
            end else if (busy_q && mul_fin) begin
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
                err_q   <= fin_err;
                valid_q <= (fin_err == '0);
            end
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign valid = valid_q;
    assign err   = err_q;
endmodule

// File: rtl/pll_cfg_checker_sva.sv
// Module: protocol and result-shape properties for pll_cfg_checker.
// Assumes: attached by bind; observes ports only.
module pll_cfg_checker_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       valid,
    input logic [7:0] err
);
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(err) && $stable(valid)));
    a_r5_enc_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (err[1:0] != 2'b00) |-> (err[7:2] == 6'b0));
    a_r6_fdiv_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err[3:2]));
    a_r8_j_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err[5:4]));
    a_r10_vco_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(err[7:6]));
    a_r11_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (err == 8'b0));
endmodule

bind pll_cfg_checker pll_cfg_checker_sva u_sva (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .valid(valid), .err(err)
);

// File: tb/pll_cfg_checker_test.sv
`timescale 1ns/1ps
module pll_cfg_checker_test;
    localparam int EXP_LAT = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [16:0] mclk_khz = '0;
    logic [3:0]  pdiv = '0;
    logic [5:0]  jmul = '0;
    logic [13:0] dfrac = '0;
    logic        busy, done, valid;
    logic [7:0]  err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pll_cfg_checker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mclk_khz(mclk_khz),
        .pdiv(pdiv), .jmul(jmul), .dfrac(dfrac),
        .busy(busy), .done(done), .valid(valid), .err(err)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(input int m, input int p, input int j, input int d);
        mclk_khz = 17'(m);
        pdiv     = 4'(p);
        jmul     = 6'(j);
        dfrac    = 14'(d);
    endtask

    // Run one setting, check latency, err, valid, then check holding.
    task automatic run_cfg(input string tag, input int m, input int p, input int j,
                           input int d, input logic [7:0] exp_err);
        int n;
        logic [7:0] e_seen;
        logic v_seen;
        @(negedge clk);
        drive(m, p, j, d);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n = 1;
        chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
        while (!done && n < 100) begin
            @(posedge clk); #1;
            n++;
        end
        chk(n == EXP_LAT, "R2", "latency", n, EXP_LAT);
        chk(err == exp_err, tag, "err", err, exp_err);
        chk(valid == (exp_err == 8'h00), "R11", "valid", valid, (exp_err == 8'h00));
        chk(busy == 1'b0, "R2", "busy at done", busy, 0);
        e_seen = err;
        v_seen = valid;
        drive(1, 0, 63, 16383);
        repeat (3) @(posedge clk);
        #1;
        chk(done == 1'b0, "R4", "done one cycle", done, 0);
        chk(err == e_seen && valid == v_seen, "R4", "held err", err, e_seen);
    endtask

    // Start pulsed mid-run with a bad setting must not disturb the check (R3).
    task automatic run_busy_ignore();
        int n;
        @(negedge clk);
        drive(12000, 1, 7, 5264);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n = 1;
        repeat (5) begin @(posedge clk); #1; n++; end
        @(negedge clk);
        drive(12000, 0, 3, 10000);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n++;
        while (!done && n < 100) begin
            @(posedge clk); #1;
            n++;
        end
        chk(n == EXP_LAT, "R3", "latency with stray start", n, EXP_LAT);
        chk(err == 8'h00 && valid, "R3", "result of captured setting", err, 0);
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 1'b0, "R3", "no second run", busy, 0);
    endtask

    task automatic run_reset();
        chk(busy == 0 && done == 0 && valid == 0, "R1", "flags in reset", {busy, done, valid}, 0);
        chk(err == 8'h00, "R1", "err in reset", err, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(busy == 0 && done == 0 && valid == 0 && err == 0, "R1", "after release",
            {busy, done, valid, err}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        run_reset();
        run_cfg("R12", 12000, 1, 7, 5264, 8'h00);
        run_cfg("R12", 12000, 1, 8, 1920, 8'h00);
        run_cfg("R6", 12000, 1, 8, 0, 8'h00);
        run_cfg("R6", 1500, 1, 55, 0, 8'h04);
        run_cfg("R8", 2000, 1, 55, 0, 8'h00);
        run_cfg("R6", 42000, 2, 5, 0, 8'h08);
        run_cfg("R7", 8000, 1, 11, 5000, 8'h04);
        run_cfg("R7", 8000, 1, 11, 0, 8'h00);
        run_cfg("R9", 12000, 1, 12, 1, 8'hA0);
        run_cfg("R9", 12000, 1, 12, 0, 8'h80);
        run_cfg("R8", 20000, 1, 3, 0, 8'h50);
        run_cfg("R10", 16000, 2, 10, 0, 8'h00);
        run_cfg("R10", 15999, 2, 10, 0, 8'h40);
        run_cfg("R5", 12000, 0, 8, 1920, 8'h01);
        run_cfg("R5", 12000, 1, 8, 10000, 8'h02);
        run_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                failures++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule